// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page-Buffered Writes

This block is a slave on a two-wire serial bus and behaves like a small serial EEPROM. The system clock samples the bus clock and data lines. The block recognises START and STOP conditions and answers a control byte that carries its device tag and strap address. It then accepts a word address and data bytes, or returns data. The block drives the data line only through an open-drain pull-down output. The chip wires that output, together with the master's driver, into one wired-AND line.

Written bytes are gathered in a page buffer that holds one row of the array. The buffer is committed to the array in one step when STOP arrives, and a self-timed busy period follows. The array comes out of reset fully erased (every byte 0xFF). Reads start at an internal address pointer. A write-addressed transaction sets that pointer, and an acknowledged read byte advances it. A master that wants a random read sends a write control byte and an address byte, then a repeated START and a read control byte.

Top module: `eep_slave`

## Requirements
- R1: After reset the pull-down output is released, every array byte reads 0xFF and the address pointer is 0.
- R2: The slave acknowledges a control byte only if bits 7:4 are 1010 and bits 3:1 equal `blk_sel_i`. Bit 0 = 1 selects a read and 0 selects a write. On any other control byte the slave gives no acknowledge and ignores the bus until the next START.
- R3: Each received byte is acknowledged by pulling the line low for the whole high period of the ninth clock. In a write, the byte after the control byte is the word address. Its bits 7:4 pick the page and bits 3:0 pick the byte in the page. The following data bytes go to consecutive page slots, and the loaded slots are written to the array at STOP.
- R4: Data bytes past the end of the page wrap to slot 0 of the same page and overwrite what was loaded there earlier.
- R5: A commit changes only the page slots that were loaded. Every other byte keeps its value.
- R6: A byte cut short by STOP is discarded, and the bytes already complete are still written.
- R7: After a commit the slave stays busy for `WR_CYCLES` clocks. During that time it ignores START and STOP and never pulls the line.
- R8: Read data is sent MSB first. Each bit is driven after a falling edge of the bus clock and is held through the following high period.
- R9: Each read byte that the master acknowledges advances the pointer by one across the whole array. The pointer wraps from the last location to location 0.
- R10: If the master does not acknowledge a read byte, the slave releases the line and waits for START. The pointer stays on the byte that was not acknowledged.
- R11: A START in the middle of an operation ends it. Loaded write data is dropped without a commit, and decoding starts again with a new control byte.
- R12: A read control byte with no preceding address byte reads from the current pointer. After a write, the pointer is one past the last loaded slot, within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| blk_sel_i | input | 3 | Strap address compared with control bits 3:1 |
| sda_pull_o | output | 1 | 1 = pull the data line low |

## Verification
The hardest states to reach from the ports are those where the write path and the bus framing interact. These are a STOP arriving partway through a byte, a repeated START that arrives after data is loaded but before any STOP, and a control byte sent while the self-timed commit is still running. The bench reaches them with a bit-level master. That master can stop after any number of bits, issue a repeated START right after an acknowledge, and probe the bus right after a commit. A behavioural model of the array, the page buffer and the pointer predicts every bit the slave must or must not drive.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [1:0] {RX_CTRL, RX_ADDR, RX_DATA} rx_kind_e;
  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s_o = scl_q[1];
  assign sda_s_o = sda_q[1];
  assign start_o = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign rise_o  = scl_q[1] & ~scl_q[2];
  assign fall_o  = ~scl_q[1] & scl_q[2];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [7:0]              data_i,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr_i)     mask_d = '0;
    else if (wr_i) mask_d[idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_i && (idx_i == IDX_W'(i))) slot_q <= data_i;
    end
    assign data_o[i*8 +: 8] = slot_q;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [7:0]              rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int                OFS = g % PAGE_BYTES;
    localparam logic [PAGE_W-1:0] PG  = PAGE_W'(g / PAGE_BYTES);
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= 8'hFF;
      else if (commit_i && (page_i == PG) && mask_i[OFS])
        cell_q <= data_i[OFS*8 +: 8];
    end
    assign cells[g] = cell_q;
  end

  assign rdata_o = cells[raddr_i];

  // A commit without any loaded slot would be a wasted busy period
  assert_commit_has_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (mask_i != '0));
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] blk_sel_i,
  output logic       sda_pull_o
);
  import eep_pkg::*;
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_l = rst_q[1];

  logic scl_s, sda_s, start, stop, rise, fall;
  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_l), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s_o(scl_s), .sda_s_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall));

  bus_st_e             st_q, st_d;
  rx_kind_e            kind_q, kind_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [7:0]          sr_q, sr_d, tx_q, tx_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic                drv_q, drv_d, rd_q, rd_d;
  logic [BUSY_W-1:0]   busy_q, busy_d;
  logic                busy, buf_wr, buf_clr, commit;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [7:0]          rdata;

  assign busy = (busy_q != '0);

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_l), .clr_i(buf_clr), .wr_i(buf_wr),
    .idx_i(ptr_q[IDX_W-1:0]), .data_i(sr_q), .data_o(buf_data), .mask_o(buf_mask));

  eep_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_l), .commit_i(commit), .page_i(ptr_q[ADDR_W-1:IDX_W]),
    .data_i(buf_data), .mask_i(buf_mask), .raddr_i(ptr_q), .rdata_o(rdata));

  always_comb begin
    st_d = st_q; kind_d = kind_q; cnt_d = cnt_q; sr_d = sr_q; tx_d = tx_q;
    ptr_d = ptr_q; drv_d = drv_q; rd_d = rd_q; busy_d = busy_q;
    buf_wr = 1'b0; buf_clr = 1'b0; commit = 1'b0;
    if (busy) begin
      busy_d = busy_q - BUSY_W'(1);
      st_d   = ST_IDLE;
      drv_d  = 1'b0;
    end else if (start) begin
      st_d = ST_RX; kind_d = RX_CTRL; cnt_d = '0; drv_d = 1'b0; buf_clr = 1'b1;
    end else if (stop) begin
      st_d = ST_IDLE; drv_d = 1'b0; buf_clr = 1'b1;
      if (buf_mask != '0) begin
        commit = 1'b1;
        busy_d = BUSY_W'(WR_CYCLES);
      end
    end else begin
      case (st_q)
        ST_RX: begin
          if (rise && cnt_q < 4'd8) begin
            sr_d  = {sr_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            drv_d = 1'b1;
            st_d  = ST_ACK;
            case (kind_q)
              RX_CTRL: begin
                rd_d = sr_q[0];
                if (sr_q[7:4] != DEV_TAG || sr_q[3:1] != blk_sel_i) begin
                  drv_d = 1'b0;
                  st_d  = ST_IDLE;
                end
              end
              RX_ADDR: ptr_d = sr_q[ADDR_W-1:0];
              default: begin
                buf_wr = 1'b1;
                ptr_d  = {ptr_q[ADDR_W-1:IDX_W], IDX_W'(ptr_q[IDX_W-1:0] + 1'b1)};
              end
            endcase
          end
        end
        ST_ACK: begin
          if (fall) begin
            cnt_d = '0;
            if (kind_q == RX_CTRL && rd_q) begin
              st_d  = ST_TX;
              tx_d  = {rdata[6:0], 1'b0};
              drv_d = ~rdata[7];
            end else begin
              st_d   = ST_RX;
              drv_d  = 1'b0;
              kind_d = (kind_q == RX_CTRL) ? RX_ADDR : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (rise) cnt_d = cnt_q + 4'd1;
          else if (fall) begin
            if (cnt_q == 4'd8) begin
              drv_d = 1'b0;
              st_d  = ST_MACK;
            end else begin
              drv_d = ~tx_q[7];
              tx_d  = {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (rise) begin
            if (sda_s) st_d = ST_IDLE;
            else begin
              ptr_d = ptr_q + 1'b1;
              cnt_d = 4'd9;
            end
          end else if (fall && cnt_q == 4'd9) begin
            st_d  = ST_TX;
            cnt_d = '0;
            tx_d  = {rdata[6:0], 1'b0};
            drv_d = ~rdata[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= ST_IDLE; kind_q <= RX_CTRL; cnt_q <= '0; sr_q <= '0; tx_q <= '0;
      ptr_q <= '0; drv_q <= 1'b0; rd_q <= 1'b0; busy_q <= '0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; cnt_q <= cnt_d; sr_q <= sr_d; tx_q <= tx_d;
      ptr_q <= ptr_d; drv_q <= drv_d; rd_q <= rd_d; busy_q <= busy_d;
    end
  end

  assign sda_pull_o = drv_q;

  // R8: the slave never moves the line while the bus clock is high
  assert_pull_stable_R8: assert property (@(posedge clk) disable iff (!rst_l)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
  // R7: silent for the whole self-timed cycle
  assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rst_l)
    busy |-> !sda_pull_o);
  assert_commit_starts_busy_R7: assert property (@(posedge clk) disable iff (!rst_l)
    commit |=> busy);
  // R10: a missing master acknowledge returns the slave to standby
  assert_nack_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_MACK && rise && sda_s && !busy) |=> (st_q == ST_IDLE && !sda_pull_o));
endmodule

// File: tb/tb_eep_slave.sv
module tb_eep_slave;
  localparam int WR = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int n_vec = 0, n_bad = 0;
  logic [7:0] mem_m [256];
  logic [7:0] ptr_m = 8'h00;

  always #5 clk = ~clk;

  eep_slave #(.ADDR_W(8), .PAGE_BYTES(16), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .blk_sel_i(STRAP), .sda_pull_o(sda_pull));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pull got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic bus_bit(input logic mval, input logic exp_pull, input string req);
    sda_m = mval; tick(4);
    scl_m = 1'b1; tick(4);
    chk(sda_pull, exp_pull, req);
    tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req);
    bus_bit(1'b1, ack, req);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, ~exp[i], req);
    bus_bit(~mack, 1'b0, req);
  endtask

  // write transaction: model page buffer, wrap, partial byte, commit at STOP
  task automatic wr_txn(input logic [7:0] addr, input logic [7:0] d[$], input int part,
                        input bit probe, input string req);
    logic [7:0] pb [16];
    bit pm [16];
    int idx;
    bit loaded;
    for (int i = 0; i < 16; i++) pm[i] = 1'b0;
    bus_start();
    send_byte(CW, 1'b1, req);
    send_byte(addr, 1'b1, req);
    idx = int'(addr[3:0]);
    foreach (d[k]) begin
      send_byte(d[k], 1'b1, req);
      pb[idx] = d[k]; pm[idx] = 1'b1; idx = (idx + 1) % 16;
    end
    for (int b = 0; b < part; b++) bus_bit(b[0], 1'b0, req);
    bus_stop();
    loaded = 1'b0;
    for (int i = 0; i < 16; i++)
      if (pm[i]) begin mem_m[{addr[7:4], 4'(i)}] = pb[i]; loaded = 1'b1; end
    ptr_m = {addr[7:4], 4'(idx)};
    if (probe) begin
      // R7: control byte during the self-timed cycle gets no acknowledge
      bus_start();
      send_byte(CW, 1'b0, "R7");
      bus_stop();
    end
    if (loaded) tick(WR + 20);
  endtask

  task automatic rd_txn(input bit set_addr, input logic [7:0] addr, input int n, input string req);
    if (set_addr) begin
      bus_start();
      send_byte(CW, 1'b1, req);
      send_byte(addr, 1'b1, req);
      ptr_m = addr;
    end
    bus_start();
    send_byte(CR, 1'b1, req);
    for (int k = 0; k < n; k++) begin
      bit ma;
      ma = (k < n - 1);
      recv_byte(mem_m[ptr_m], ma, req);
      if (ma) ptr_m = ptr_m + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    chk(sda_pull, 1'b0, "R1");
    rd_txn(1'b0, 8'h00, 1, "R1");
    rd_txn(1'b1, 8'h00, 2, "R1");

    // R2: wrong tag, wrong strap, then a valid pattern with no START
    bus_start();
    send_byte(8'hBA, 1'b0, "R2");
    send_byte(CW, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, 1'b0, "R2");
    bus_stop();

    // R3 write with R7 busy probe, then R8 random read back
    q = '{8'h11, 8'h22, 8'h33};
    wr_txn(8'h23, q, 0, 1'b1, "R3");
    rd_txn(1'b1, 8'h23, 3, "R8");
    // R5: rest of the page untouched
    rd_txn(1'b1, 8'h20, 16, "R5");

    // R4: 18 bytes from slot 14 wrap within the page
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(8'(8'h40 + i));
    wr_txn(8'h5E, q, 0, 1'b0, "R4");
    rd_txn(1'b1, 8'h50, 16, "R4");
    // R12: pointer after write is one past last loaded slot
    wr_txn(8'h5E, q, 0, 1'b0, "R12");
    rd_txn(1'b0, 8'h00, 2, "R12");

    // R6: two bytes then a 5-bit fragment
    q = '{8'hC3, 8'h3C};
    wr_txn(8'h70, q, 5, 1'b0, "R6");
    rd_txn(1'b1, 8'h70, 3, "R6");

    // R11: repeated START after a loaded data byte drops it
    bus_start();
    send_byte(CW, 1'b1, "R11");
    send_byte(8'h90, 1'b1, "R11");
    send_byte(8'h55, 1'b1, "R11");
    ptr_m = 8'h91;
    bus_start();
    send_byte(CR, 1'b1, "R11");
    recv_byte(mem_m[ptr_m], 1'b0, "R11");
    bus_stop();
    rd_txn(1'b1, 8'h90, 2, "R11");

    // R9: read wraps from the top of the array
    q = '{8'h5C};
    wr_txn(8'h00, q, 0, 1'b0, "R9");
    q = '{8'hAA, 8'hBB};
    wr_txn(8'hFE, q, 0, 1'b0, "R9");
    rd_txn(1'b1, 8'hFE, 3, "R9");
    rd_txn(1'b0, 8'h00, 1, "R12");

    // R10: NACK leaves the pointer on the same byte
    rd_txn(1'b1, 8'h23, 1, "R10");
    rd_txn(1'b0, 8'h00, 2, "R10");

    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule